// File: doc/BRIEF.md
# Frame Pulse Format Detector and Bit Timing

This block recovers serial-backplane timing from a 4.096 MHz master clock and a frame-sync line. Both inputs are brought into a faster system clock domain, at least four times the master rate, and master-clock edges are found there synchronously. The block first looks at the level the frame-sync line rests at. A line that rests high carries an active-low frame pulse. A line that rests low carries an active-high frame pulse, as on GCI backplanes.

Once the polarity is known, the block hunts for frame pulses on the bit-boundary edge that belongs to that format. It declares lock when the pulses come at the right spacing. While locked it runs two counters: the bit within the channel and the channel within the frame. It also emits a single-cycle transmit strobe at every bit boundary and a single-cycle sample strobe three quarters of the way into each bit cell. The switch core uses these strobes to shift serial data out and to capture it. If a frame pulse shows up where it should not, lock is dropped and the whole detection runs again.

Top module: `frame_timing_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `locked`, `fmt_active_high`, `tx_stb`, `smp_stb`, `bit_idx` and `chan_idx` are all 0.
- R2: After sixteen consecutive master-clock rising edges that all see the same frame-sync level, the format is fixed. `fmt_active_high` is 0 when that level is high (active-low pulse) and 1 when it is low (active-high pulse).
- R3: A frame pulse is a boundary edge at which frame sync is at its active level, where it was inactive at the previous boundary edge. The boundary edge is the falling master-clock edge when `fmt_active_high`=0 and the rising edge when it is 1. `locked` rises at the third of three consecutive pulses that are each 512 master-clock cycles apart.
- R4: Pulses whose spacing is not 512 master-clock cycles never set `locked`.
- R5: While locked, `tx_stb` is high for exactly one system clock, three system clocks after every second boundary edge. This includes the boundary edge that carries the frame pulse.
- R6: While locked, `smp_stb` is high for exactly one system clock, three system clocks after the opposite-polarity master-clock edge that falls three quarters of the way through each bit cell.
- R7: Let n be the number of master-clock cycles since the frame pulse, counting the frame-pulse boundary edge as n=0. Then `bit_idx` = (n/2) mod 8 and `chan_idx` = n/16. Both are 0 at the frame pulse, and `bit_idx` changes only together with `tx_stb` while locked.
- R8: If frame pulses stop after lock, `locked` stays high, and the counters and strobes keep running with a 512-cycle wrap.
- R9: A frame pulse at any other position while locked clears `locked` and restarts format detection. The block locks again on the pulses that follow.
- R10: `tx_stb` and `smp_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the master clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | 4.096 MHz master clock, asynchronous to `clk` |
| fsync_in | input | 1 | Frame-sync line, either polarity |
| fmt_active_high | output | 1 | 1 = active-high frame pulse, 0 = active-low |
| locked | output | 1 | Frame timing locked |
| bit_idx | output | 3 | Bit position within the channel |
| chan_idx | output | 5 | Channel position within the frame |
| tx_stb | output | 1 | One-cycle strobe at each bit boundary |
| smp_stb | output | 1 | One-cycle strobe at three quarters of each bit cell |

## Verification
A master-clock edge that the bench drives appears on the strobes and counters three system clocks later. Two of those clocks are synchronizer stages and one is the output register. The bench changes master clock and frame sync only at falling `clk` edges and holds each half period for four system clocks. It compares the strobes and counters at the third falling edge after each master-clock edge, and requires both strobes to be low at the other three. Lock and format are checked only after several whole frames have passed, which is more than the one frame for polarity detection plus the three pulses the lock rule needs.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    // Master-clock periods that make up one serial bit (4.096 MHz / 2.048 Mb/s).
    localparam int MCLK_PER_BIT = 2;

    typedef enum logic {
        FMT_ACTIVE_LOW  = 1'b0,
        FMT_ACTIVE_HIGH = 1'b1
    } fp_fmt_e;

    typedef enum logic [1:0] {
        PH_NOREF  = 2'd0,
        PH_COUNT  = 2'd1,
        PH_LOCKED = 2'd2
    } track_ph_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } mclk_ev_t;

    // A line that rests high carries active-low pulses, and the reverse.
    function automatic fp_fmt_e fmt_from_rest(input logic rest_lvl);
        return rest_lvl ? FMT_ACTIVE_LOW : FMT_ACTIVE_HIGH;
    endfunction

endpackage

// File: rtl/fpt_edge_sync.sv
module fpt_edge_sync
    import fpt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     mclk_in,
    input  logic     fs_in,
    output mclk_ev_t ev,
    output logic     fs_lvl
);

    logic [STAGES-1:0] mc_sr;
    logic [STAGES-1:0] fs_sr;
    logic              mc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_sr   <= '0;
            fs_sr   <= '0;
            mc_prev <= 1'b0;
        end else begin
            mc_sr   <= {mc_sr[STAGES-2:0], mclk_in};
            fs_sr   <= {fs_sr[STAGES-2:0], fs_in};
            mc_prev <= mc_sr[STAGES-1];
        end
    end

    assign ev.rise = mc_sr[STAGES-1] & ~mc_prev;
    assign ev.fall = ~mc_sr[STAGES-1] & mc_prev;
    assign fs_lvl  = fs_sr[STAGES-1];

endmodule

// File: rtl/fpt_fmt_detect.sv
module fpt_fmt_detect
    import fpt_pkg::*;
#(
    parameter int IDLE_MCLK = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  logic    mclk_rise,
    input  logic    fs_lvl,
    output fp_fmt_e fmt,
    output logic    known
);

    localparam int IC_W = (IDLE_MCLK > 1) ? $clog2(IDLE_MCLK) : 1;

    logic [IC_W-1:0] run_cnt;
    logic            last_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            last_lvl <= 1'b0;
            known    <= 1'b0;
            fmt      <= FMT_ACTIVE_LOW;
        end else if (restart) begin
            run_cnt <= '0;
            known   <= 1'b0;
        end else if (mclk_rise && !known) begin
            if (fs_lvl != last_lvl) begin
                last_lvl <= fs_lvl;
                run_cnt  <= '0;
            end else if (run_cnt == IC_W'(IDLE_MCLK - 1)) begin
                known <= 1'b1;
                fmt   <= fmt_from_rest(fs_lvl);
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpt_frame_track.sv
module fpt_frame_track
    import fpt_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int CHANS       = 32,
    parameter int LOCK_FRAMES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  mclk_ev_t                   ev,
    input  logic                       fs_lvl,
    input  fp_fmt_e                    fmt,
    input  logic                       fmt_known,
    output logic                       restart,
    output logic                       locked,
    output logic [$clog2(BITS)-1:0]    bit_idx,
    output logic [$clog2(CHANS)-1:0]   chan_idx,
    output logic                       tx_stb,
    output logic                       smp_stb
);

    localparam int BW    = $clog2(BITS);
    localparam int CW    = $clog2(CHANS);
    localparam int FRAME = MCLK_PER_BIT * BITS * CHANS;
    localparam int FW    = $clog2(FRAME);
    localparam int GW    = $clog2(LOCK_FRAMES + 1);

    track_ph_e     ph;
    logic [FW-1:0] mcnt;
    logic [GW-1:0] good;
    logic          prev_act;

    logic bnd, opp, act, at_last;

    always_comb begin
        bnd     = (fmt == FMT_ACTIVE_HIGH) ? ev.rise : ev.fall;
        opp     = (fmt == FMT_ACTIVE_HIGH) ? ev.fall : ev.rise;
        act     = (fmt == FMT_ACTIVE_HIGH) ? fs_lvl : ~fs_lvl;
        at_last = (mcnt == FW'(FRAME - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_NOREF;
            mcnt     <= '0;
            good     <= '0;
            prev_act <= 1'b0;
            tx_stb   <= 1'b0;
            smp_stb  <= 1'b0;
            restart  <= 1'b0;
        end else begin
            tx_stb  <= 1'b0;
            smp_stb <= 1'b0;
            restart <= 1'b0;
            if (!fmt_known) begin
                ph   <= PH_NOREF;
                good <= '0;
            end else if (bnd) begin
                prev_act <= act;
                if (act && !prev_act) begin
                    mcnt <= '0;
                    case (ph)
                        PH_LOCKED: begin
                            if (at_last) begin
                                tx_stb <= 1'b1;
                            end else begin
                                ph      <= PH_NOREF;
                                good    <= '0;
                                restart <= 1'b1;
                            end
                        end
                        PH_COUNT: begin
                            if (!at_last) begin
                                good <= '0;
                            end else if (good == GW'(LOCK_FRAMES - 1)) begin
                                ph     <= PH_LOCKED;
                                good   <= '0;
                                tx_stb <= 1'b1;
                            end else begin
                                good <= good + 1'b1;
                            end
                        end
                        default: begin
                            ph   <= PH_COUNT;
                            good <= '0;
                        end
                    endcase
                end else begin
                    mcnt   <= at_last ? '0 : mcnt + 1'b1;
                    tx_stb <= (ph == PH_LOCKED) && (at_last || mcnt[0]);
                end
            end else if (opp && ph == PH_LOCKED) begin
                smp_stb <= mcnt[0];
            end
        end
    end

    assign locked   = (ph == PH_LOCKED);
    assign bit_idx  = mcnt[BW:1];
    assign chan_idx = mcnt[BW+CW:BW+1];

endmodule

// File: rtl/frame_timing_unit.sv
module frame_timing_unit
    import fpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_MCLK   = 16,
    parameter int LOCK_FRAMES = 2,
    parameter int BITS        = 8,
    parameter int CHANS       = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mclk_in,
    input  logic                     fsync_in,
    output logic                     fmt_active_high,
    output logic                     locked,
    output logic [$clog2(BITS)-1:0]  bit_idx,
    output logic [$clog2(CHANS)-1:0] chan_idx,
    output logic                     tx_stb,
    output logic                     smp_stb
);

    mclk_ev_t ev;
    logic     fs_lvl;
    fp_fmt_e  fmt;
    logic     fmt_known;
    logic     restart;

    fpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .mclk_in (mclk_in),
        .fs_in   (fsync_in),
        .ev      (ev),
        .fs_lvl  (fs_lvl)
    );

    fpt_fmt_detect #(.IDLE_MCLK(IDLE_MCLK)) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .mclk_rise (ev.rise),
        .fs_lvl    (fs_lvl),
        .fmt       (fmt),
        .known     (fmt_known)
    );

    fpt_frame_track #(
        .BITS        (BITS),
        .CHANS       (CHANS),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .fs_lvl    (fs_lvl),
        .fmt       (fmt),
        .fmt_known (fmt_known),
        .restart   (restart),
        .locked    (locked),
        .bit_idx   (bit_idx),
        .chan_idx  (chan_idx),
        .tx_stb    (tx_stb),
        .smp_stb   (smp_stb)
    );

    assign fmt_active_high = (fmt == FMT_ACTIVE_HIGH);

endmodule

// File: rtl/frame_timing_chk.sv
module frame_timing_chk #(
    parameter int BW = 3,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          locked,
    input logic [BW-1:0] bit_idx,
    input logic [CW-1:0] chan_idx,
    input logic          tx_stb,
    input logic          smp_stb
);

    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_stb |=> !tx_stb);                                              // R5

    AST_SMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> !smp_stb);                                            // R6

    AST_STB_APART: assert property (@(posedge clk) disable iff (rst)
        !(tx_stb && smp_stb));                                            // R10

    AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (tx_stb || smp_stb) |-> locked);                                  // R5

    AST_LOCK_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (bit_idx == '0 && chan_idx == '0));             // R7

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && !tx_stb) |-> $stable(bit_idx));       // R7

endmodule

bind frame_timing_unit frame_timing_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .locked   (locked),
    .bit_idx  (bit_idx),
    .chan_idx (chan_idx),
    .tx_stb   (tx_stb),
    .smp_stb  (smp_stb)
);

// File: tb/sim_frame_timing_unit.sv
module sim_frame_timing_unit;

    localparam int H     = 4;     // system clocks per master-clock half period
    localparam int FRAME = 512;   // master-clock cycles per frame

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk_in = 1'b0;
    logic       fsync_in = 1'b1;
    logic       fmt_active_high, locked, tx_stb, smp_stb;
    logic [2:0] bit_idx;
    logic [4:0] chan_idx;

    always #2 clk = ~clk;   // 250 MHz

    frame_timing_unit u0 (
        .clk             (clk),
        .rst             (rst),
        .mclk_in         (mclk_in),
        .fsync_in        (fsync_in),
        .fmt_active_high (fmt_active_high),
        .locked          (locked),
        .bit_idx         (bit_idx),
        .chan_idx        (chan_idx),
        .tx_stb          (tx_stb),
        .smp_stb         (smp_stb)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // stimulus controls
    bit gci      = 1'b0;
    int flen     = FRAME;
    bit pulse_en = 1'b1;
    bit inj_en   = 1'b0;
    int inj_pos  = 100;
    bit chk_en   = 1'b0;
    int fpos     = 0;

    // monitor error counters
    int tx_err  = 0;
    int smp_err = 0;
    int cnt_err = 0;
    int lck_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_errs();
        tx_err = 0; smp_err = 0; cnt_err = 0; lck_err = 0;
    endtask

    task automatic wait_frames(input int n);
        repeat (n * FRAME * 2 * H) @(negedge clk);
    endtask

    // Master clock and frame-sync generator with a strobe/counter monitor.
    initial begin
        forever begin
            bit fs_act;
            mclk_in  = gci ? 1'b0 : 1'b1;
            fs_act   = (pulse_en && fpos == 0) || (inj_en && fpos == inj_pos);
            fsync_in = gci ? fs_act : !fs_act;
            for (int k = 1; k <= H; k++) begin
                @(negedge clk);
                if (chk_en) begin
                    if (smp_stb !== ((k == 3) && (fpos % 2 == 0))) smp_err++;
                    if (tx_stb !== 1'b0) tx_err++;
                    if (locked !== 1'b1) lck_err++;
                end
            end
            mclk_in = ~mclk_in;
            for (int k = 1; k <= H; k++) begin
                @(negedge clk);
                if (chk_en) begin
                    if (tx_stb !== ((k == 3) && (fpos % 2 == 0))) tx_err++;
                    if (smp_stb !== 1'b0) smp_err++;
                    if (locked !== 1'b1) lck_err++;
                    if (k == 3 && (int'(bit_idx) != (fpos / 2) % 8 ||
                                   int'(chan_idx) != fpos / 16)) cnt_err++;
                end
            end
            fpos = (fpos + 1 >= flen) ? 0 : fpos + 1;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(locked == 0 && fmt_active_high == 0, "R1 lock/format in reset",
              {locked, fmt_active_high}, 0);
        check(tx_stb == 0 && smp_stb == 0, "R1 strobes in reset", {tx_stb, smp_stb}, 0);
        check(bit_idx == 0 && chan_idx == 0, "R1 counters in reset",
              {chan_idx, bit_idx}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(locked == 0 && tx_stb == 0 && smp_stb == 0, "R1 first cycle after reset",
              {locked, tx_stb, smp_stb}, 0);
    endtask

    task automatic run_monitor(input int frames, input string tag);
        clear_errs();
        chk_en = 1'b1;
        wait_frames(frames);
        chk_en = 1'b0;
        check(tx_err == 0,  {tag, " R5 transmit strobe timing"}, tx_err, 0);
        check(smp_err == 0, {tag, " R6 sample strobe timing"}, smp_err, 0);
        check(cnt_err == 0, {tag, " R7 bit/channel counters"}, cnt_err, 0);
        check(lck_err == 0, {tag, " R8 lock held"}, lck_err, 0);
    endtask

    task automatic test_low_format();
        gci = 1'b0; flen = FRAME; pulse_en = 1'b1;
        do_reset();
        wait_frames(5);
        check(fmt_active_high == 0, "R2 rest-high line gives active-low format", fmt_active_high, 0);
        check(locked == 1, "R3 lock on 512-spaced pulses (active-low)", locked, 1);
        run_monitor(2, "active-low");
    endtask

    task automatic test_flywheel();
        pulse_en = 1'b0;
        run_monitor(2, "no pulses");
        pulse_en = 1'b1;
        check(locked == 1, "R8 lock kept without pulses", locked, 1);
    endtask

    task automatic test_wrong_pos();
        wait (fpos == 0);
        inj_pos = 100;
        inj_en  = 1'b1;
        wait (fpos == 110);
        inj_en  = 1'b0;
        @(negedge clk);
        check(locked == 0, "R9 misplaced pulse clears lock", locked, 0);
        wait_frames(5);
        check(locked == 1, "R9 relock after misplaced pulse", locked, 1);
        check(fmt_active_high == 0, "R9 format re-detected unchanged", fmt_active_high, 0);
        run_monitor(1, "relocked");
    endtask

    task automatic test_gci_switch();
        wait (fpos == 200);
        gci = 1'b1;
        wait_frames(6);
        check(fmt_active_high == 1, "R2 rest-low line gives active-high format", fmt_active_high, 1);
        check(locked == 1, "R3 lock on 512-spaced pulses (active-high)", locked, 1);
        run_monitor(2, "active-high");
    endtask

    task automatic test_bad_spacing();
        gci = 1'b0; flen = 500; pulse_en = 1'b1;
        do_reset();
        wait_frames(6);
        check(locked == 0, "R4 no lock on 500-cycle spacing", locked, 0);
        check(fmt_active_high == 0, "R2 format found without lock", fmt_active_high, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_low_format();
        test_flywheel();
        test_wrong_pos();
        test_gci_switch();
        test_bad_spacing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 190000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule